// File: doc/BRIEF.md
# CAN Interframe Space Sequencer

This block follows a CAN 2.0B node through the gap between frames. A pulse on `frame_done`, given together with the bit strobe on the last end-of-frame bit, starts a three-bit intermission. For an error-passive node that really transmitted the frame just finished, an eight-bit suspend-transmission field follows the intermission. Otherwise the node goes straight to bus idle. In each of these phases the block decides whether a dominant bit on the bus is a start of frame or an overload condition. It also decides when a pending transmit request may begin.

The node's bit-timing logic supplies the sampled bus level together with a one-clock strobe at the sample point. The frame logic supplies three flags when the frame ends: whether the node transmitted, whether it lost arbitration, and whether it is error passive. Every result is a one-clock registered pulse that appears on the clock after the strobe that caused it. The block also counts runs of recessive bits and reports each bus-free run to fault confinement. After reset it uses that count to integrate onto the bus.

Top module: `ifs_sequencer`

## Requirements
- R1: After reset all outputs are low and the block treats the bus as busy. A transmit request cannot start until 11 consecutive recessive bits have been sampled. The first start then comes on the following strobe.
- R2: `bus_free` pulses once for every 11 consecutive recessive bits sampled on strobes. A dominant bit restarts the count, and after each pulse the count starts again from zero.
- R3: A strobe with `frame_done` high while the bus is busy starts intermission. The next three strobes are intermission bits 1 to 2 to 3, and recessive bits 1 and 2 produce no output.
- R4: A dominant bit in intermission bit 1 or 2 gives an `overload_req` pulse with no `sof_det` and no `start_tx`. The block then treats the bus as busy.
- R5: A dominant bit in intermission bit 3 gives `sof_det`. If `tx_req` is high, `start_tx` pulses in the same cycle, so the node joins arbitration at the identifier. This holds even when the previous frame was lost in arbitration.
- R6: Suspend transmission is inserted only when, at `frame_done`, `err_passive`=1, `was_tx`=1 and `arb_lost`=0. A request that is pending throughout then starts on the 11th strobe after `frame_done` and not earlier.
- R7: An error-passive node with `arb_lost`=1 gets no suspend field. A pending request starts on the 3rd strobe after `frame_done`, which is the recessive third intermission bit.
- R8: A dominant bit during suspend transmission gives `sof_det` without `start_tx`, even with `tx_req` high.
- R9: In bus idle, a recessive strobe with `tx_req` high gives `start_tx`. A dominant strobe gives `sof_det`, with `start_tx` as well when `tx_req` is high.
- R10: While the bus is busy, dominant bits and transmit requests produce no `sof_det`, `start_tx` or `overload_req`.
- R11: Every output pulse lasts exactly one clock and appears on the clock edge after the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe at the bit sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| frame_done | input | 1 | Last end-of-frame bit, qualified by `bit_tick` |
| was_tx | input | 1 | Node transmitted the frame that just ended |
| arb_lost | input | 1 | Node lost arbitration in that frame |
| err_passive | input | 1 | Node is error passive |
| tx_req | input | 1 | A frame is waiting to be sent |
| sof_det | output | 1 | Start of frame seen on the bus |
| start_tx | output | 1 | Node begins transmitting (joins at the identifier if `sof_det` is also high) |
| overload_req | output | 1 | Overload frame must be sent |
| bus_free | output | 1 | 11 consecutive recessive bits seen |

## Verification
Directed sequences place a dominant bit in each intermission position. This separates the overload response in bits 1 and 2 from the start-of-frame response in bit 3. The same sequence is run with each combination of error-passive, transmitter and arbitration-lost flags, and the strobe on which a pending request starts shows whether the suspend field was inserted. Dominant bits inside the suspend field and in idle show that only a node waiting in suspend is kept out of a contest it could otherwise join. A long random run mixes bus levels, frame ends and requests and compares every strobe against a bench model, which also exercises the recessive-run counter across phase changes.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  typedef enum logic [1:0] {
    PH_BUSY    = 2'd0,
    PH_INTERM  = 2'd1,
    PH_SUSPEND = 2'd2,
    PH_IDLE    = 2'd3
  } ifs_phase_e;

  localparam int IFS_RUN_LEN_DEF    = 11;
  localparam int IFS_INTERM_LEN_DEF = 3;
  localparam int IFS_SUSP_LEN_DEF   = 8;

endpackage

// File: rtl/ifs_bus_free.sv
module ifs_bus_free #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic run_hit,
  output logic bus_free
);
  localparam int RW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

  logic [RW-1:0] run_cnt;

  assign run_hit = bit_tick && rx_bit && (run_cnt == RW'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      bus_free <= 1'b0;
    end else begin
      bus_free <= run_hit;
      if (bit_tick) begin
        if (!rx_bit || run_hit) run_cnt <= '0;
        else                    run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R2: the run counter never passes the run length
  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, run_cnt} < (RW+1)'(RUN_LEN));

  // R2: a bus-free report only follows a sampled recessive bit
  p_free_after_rec_r2: assert property (@(posedge clk) disable iff (rst)
    bus_free |-> ($past(bit_tick) && $past(rx_bit)));

endmodule

// File: rtl/ifs_suspend_ctl.sv
module ifs_suspend_ctl (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic err_passive,
  input  logic was_tx,
  input  logic arb_lost,
  output logic suspend_due
);

  always_ff @(posedge clk) begin
    if (rst)          suspend_due <= 1'b0;
    else if (capture) suspend_due <= err_passive && was_tx && !arb_lost;
  end

  // R7: losing arbitration always clears the suspend decision
  p_lost_no_suspend_r7: assert property (@(posedge clk) disable iff (rst)
    (capture && arb_lost) |=> !suspend_due);

  // R6: a receiver never gets a suspend field
  p_rx_no_suspend_r6: assert property (@(posedge clk) disable iff (rst)
    (capture && !was_tx) |=> !suspend_due);

  // R6: the decision holds between frame ends
  p_due_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(suspend_due));

endmodule

// File: rtl/ifs_space_fsm.sv
module ifs_space_fsm
  import ifs_pkg::*;
#(
  parameter int INTERM_LEN = 3,
  parameter int SUSP_LEN   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       rx_bit,
  input  logic       frame_done,
  input  logic       tx_req,
  input  logic       run_hit,
  input  logic       suspend_due,
  output ifs_phase_e phase,
  output logic       sof_det,
  output logic       start_tx,
  output logic       overload_req
);
  localparam int MAXLEN = (INTERM_LEN > SUSP_LEN) ? INTERM_LEN : SUSP_LEN;
  localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;

  logic [CW-1:0] cnt, nx_cnt;
  ifs_phase_e    nx_phase;
  logic          nx_sof, nx_stx, nx_ov;
  logic          last_int, last_sus;

  assign last_int = (cnt == CW'(INTERM_LEN - 1));
  assign last_sus = (cnt == CW'(SUSP_LEN - 1));

  always_comb begin
    nx_phase = phase;
    nx_cnt   = cnt;
    nx_sof   = 1'b0;
    nx_stx   = 1'b0;
    nx_ov    = 1'b0;
    if (bit_tick) begin
      case (phase)
        PH_BUSY: begin
          if (frame_done) begin
            nx_phase = PH_INTERM;
            nx_cnt   = '0;
          end else if (run_hit) begin
            nx_phase = PH_IDLE;
          end
        end
        PH_INTERM: begin
          if (!rx_bit) begin
            nx_phase = PH_BUSY;
            if (last_int) begin
              nx_sof = 1'b1;
              nx_stx = tx_req;
            end else begin
              nx_ov = 1'b1;
            end
          end else if (last_int) begin
            if (suspend_due) begin
              nx_phase = PH_SUSPEND;
              nx_cnt   = '0;
            end else if (tx_req) begin
              nx_stx   = 1'b1;
              nx_phase = PH_BUSY;
            end else begin
              nx_phase = PH_IDLE;
            end
          end else begin
            nx_cnt = cnt + 1'b1;
          end
        end
        PH_SUSPEND: begin
          if (!rx_bit) begin
            nx_sof   = 1'b1;
            nx_phase = PH_BUSY;
          end else if (last_sus) begin
            if (tx_req) begin
              nx_stx   = 1'b1;
              nx_phase = PH_BUSY;
            end else begin
              nx_phase = PH_IDLE;
            end
          end else begin
            nx_cnt = cnt + 1'b1;
          end
        end
        PH_IDLE: begin
          if (!rx_bit) begin
            nx_sof   = 1'b1;
            nx_stx   = tx_req;
            nx_phase = PH_BUSY;
          end else if (tx_req) begin
            nx_stx   = 1'b1;
            nx_phase = PH_BUSY;
          end
        end
        default: nx_phase = PH_BUSY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_BUSY;
      cnt          <= '0;
      sof_det      <= 1'b0;
      start_tx     <= 1'b0;
      overload_req <= 1'b0;
    end else begin
      phase        <= nx_phase;
      cnt          <= nx_cnt;
      sof_det      <= nx_sof;
      start_tx     <= nx_stx;
      overload_req <= nx_ov;
    end
  end

  // R5: a start of frame is only reported for a sampled dominant bit
  p_sof_dominant_r5: assert property (@(posedge clk) disable iff (rst)
    sof_det |-> ($past(bit_tick) && !$past(rx_bit)));

  // R4: overload comes only from the early intermission bits
  p_overload_early_r4: assert property (@(posedge clk) disable iff (rst)
    overload_req |-> ($past(phase) == PH_INTERM && !$past(last_int)));

  // R4: overload never coincides with a start
  p_overload_alone_r4: assert property (@(posedge clk) disable iff (rst)
    !(overload_req && (sof_det || start_tx)));

  // R8: a dominant bit in suspend never launches this node
  p_no_launch_in_suspend_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SUSPEND && bit_tick && !rx_bit) |=> !start_tx);

  // R9: a start needs a pending request
  p_start_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    start_tx |-> $past(tx_req));

  // R10: the busy phase produces no frame-start decisions
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BUSY) |=> (!sof_det && !start_tx && !overload_req));

  // R11: output pulses last one clock
  p_one_clock_r11: assert property (@(posedge clk) disable iff (rst)
    (sof_det || start_tx || overload_req) |=> !(sof_det || start_tx || overload_req));

endmodule

// File: rtl/ifs_sequencer.sv
module ifs_sequencer
  import ifs_pkg::*;
#(
  parameter int RUN_LEN    = IFS_RUN_LEN_DEF,
  parameter int INTERM_LEN = IFS_INTERM_LEN_DEF,
  parameter int SUSP_LEN   = IFS_SUSP_LEN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic frame_done,
  input  logic was_tx,
  input  logic arb_lost,
  input  logic err_passive,
  input  logic tx_req,
  output logic sof_det,
  output logic start_tx,
  output logic overload_req,
  output logic bus_free
);

  ifs_phase_e phase;
  logic       run_hit;
  logic       suspend_due;
  logic       capture;

  assign capture = bit_tick && frame_done && (phase == PH_BUSY);

  ifs_bus_free #(.RUN_LEN(RUN_LEN)) u_free (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .rx_bit   (rx_bit),
    .run_hit  (run_hit),
    .bus_free (bus_free)
  );

  ifs_suspend_ctl u_susp (
    .clk         (clk),
    .rst         (rst),
    .capture     (capture),
    .err_passive (err_passive),
    .was_tx      (was_tx),
    .arb_lost    (arb_lost),
    .suspend_due (suspend_due)
  );

  ifs_space_fsm #(.INTERM_LEN(INTERM_LEN), .SUSP_LEN(SUSP_LEN)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .rx_bit       (rx_bit),
    .frame_done   (frame_done),
    .tx_req       (tx_req),
    .run_hit      (run_hit),
    .suspend_due  (suspend_due),
    .phase        (phase),
    .sof_det      (sof_det),
    .start_tx     (start_tx),
    .overload_req (overload_req)
  );

  // R1: nothing is reported while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(sof_det || start_tx || overload_req || bus_free));

endmodule

// File: tb/sim_ifs_sequencer.sv
module sim_ifs_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx_bit = 1'b1, frame_done = 1'b0;
  logic was_tx = 1'b0, arb_lost = 1'b0, err_passive = 1'b0, tx_req = 1'b0;
  logic sof_det, start_tx, overload_req, bus_free;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: 0 busy, 1 intermission, 2 suspend, 3 idle
  int m_st  = 0;
  int m_cnt = 0;
  int m_run = 0;
  bit m_sus = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifs_sequencer u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .frame_done(frame_done), .was_tx(was_tx), .arb_lost(arb_lost),
    .err_passive(err_passive), .tx_req(tx_req), .sof_det(sof_det),
    .start_tx(start_tx), .overload_req(overload_req), .bus_free(bus_free)
  );

  task automatic model(input bit rx, input bit fd, input bit tr, input bit ep,
                       input bit wt, input bit al, output logic [3:0] e);
    bit sof = 0, stx = 0, ov = 0, bf = 0;
    if (rx) begin
      m_run++;
      if (m_run == 11) begin bf = 1; m_run = 0; end
    end else m_run = 0;
    case (m_st)
      0: if (fd) begin m_st = 1; m_cnt = 0; m_sus = ep && wt && !al; end
         else if (bf) m_st = 3;
      1: if (!rx) begin
           m_st = 0;
           if (m_cnt == 2) begin sof = 1; stx = tr; end else ov = 1;
         end else if (m_cnt == 2) begin
           if (m_sus) begin m_st = 2; m_cnt = 0; end
           else if (tr) begin stx = 1; m_st = 0; end
           else m_st = 3;
         end else m_cnt++;
      2: if (!rx) begin sof = 1; m_st = 0; end
         else if (m_cnt == 7) begin
           if (tr) begin stx = 1; m_st = 0; end else m_st = 3;
         end else m_cnt++;
      default: if (!rx) begin sof = 1; stx = tr; m_st = 0; end
               else if (tr) begin stx = 1; m_st = 0; end
    endcase
    e = {sof, stx, ov, bf};
  endtask

  // one bit strobe: drive at a falling edge, check after the next rising edge
  task automatic tk(input bit rx, input bit fd, input bit tr, input bit ep,
                    input bit wt, input bit al, input string req);
    logic [3:0] exp_v, got_v;
    bit_tick = 1'b1; rx_bit = rx; frame_done = fd; tx_req = tr;
    err_passive = ep; was_tx = wt; arb_lost = al;
    model(rx, fd, tr, ep, wt, al, exp_v);
    @(negedge clk);
    got_v = {sof_det, start_tx, overload_req, bus_free};
    checks++;
    if (got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {sof,start,ovl,free} got %b expected %b", req, got_v, exp_v);
    end
    bit_tick = 1'b0; frame_done = 1'b0;
    @(negedge clk);
    got_v = {sof_det, start_tx, overload_req, bus_free};
    checks++;
    if (got_v !== 4'b0000) begin
      errors++;
      $display("FAIL R11 (%s): pulse width, got %b expected 0000", req, got_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;
    if ({sof_det, start_tx, overload_req, bus_free} !== 4'b0000) begin
      errors++;
      $display("FAIL R1: reset outputs got %b expected 0000",
               {sof_det, start_tx, overload_req, bus_free});
    end
    rst = 1'b0;
    @(negedge clk);

    // R1: integration before any start
    for (int i = 0; i < 10; i++) tk(1, 0, 1, 0, 0, 0, "R1");
    tk(1, 0, 0, 0, 0, 0, "R1");
    tk(1, 0, 1, 0, 0, 0, "R1");

    // R2: dominant restarts the recessive run
    for (int i = 0; i < 5; i++) tk(1, 0, 0, 0, 0, 0, "R2");
    tk(0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 11; i++) tk(1, 0, 0, 0, 0, 0, "R2");
    tk(0, 0, 0, 0, 0, 0, "R9");

    // R3 and R5: SOF on third intermission bit after lost arbitration
    tk(1, 1, 0, 1, 1, 1, "R3");
    tk(1, 0, 1, 0, 0, 0, "R3");
    tk(1, 0, 1, 0, 0, 0, "R3");
    tk(0, 0, 1, 0, 0, 0, "R5");

    // R4: dominant in intermission bits 1 and 2
    tk(1, 1, 0, 0, 0, 0, "R4");
    tk(0, 0, 1, 0, 0, 0, "R4");
    tk(1, 1, 0, 0, 0, 0, "R4");
    tk(1, 0, 0, 0, 0, 0, "R4");
    tk(0, 0, 1, 0, 0, 0, "R4");

    // R6: error-passive transmitter waits through suspend
    tk(1, 1, 1, 1, 1, 0, "R6");
    for (int i = 0; i < 10; i++) tk(1, 0, 1, 0, 0, 0, "R6");
    tk(1, 0, 1, 0, 0, 0, "R6");

    // R7: error-passive but arbitration lost: no suspend
    tk(1, 1, 1, 1, 1, 1, "R7");
    tk(1, 0, 1, 0, 0, 0, "R7");
    tk(1, 0, 1, 0, 0, 0, "R7");
    tk(1, 0, 1, 0, 0, 0, "R7");

    // R8: dominant during suspend
    tk(1, 1, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 5; i++) tk(1, 0, 1, 0, 0, 0, "R8");
    tk(0, 0, 1, 0, 0, 0, "R8");

    // R9: idle behaviour
    tk(1, 1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 6; i++) tk(1, 0, 0, 0, 0, 0, "R9");
    tk(1, 0, 1, 0, 0, 0, "R9");
    tk(1, 1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) tk(1, 0, 0, 0, 0, 0, "R9");
    tk(0, 0, 1, 0, 0, 0, "R9");

    // R10: busy bus ignores dominant bits and requests
    for (int i = 0; i < 4; i++) tk(0, 0, 1, 0, 0, 0, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      tk(($urandom % 5) != 0, ($urandom % 12) == 0, ($urandom % 3) == 0,
         1'($urandom), 1'($urandom), 1'($urandom), "RAND R5");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule